// File: doc/BRIEF.md
# Superscalar Instruction Buffer Dispatcher

This block sits between instruction fetch and the execution units. Each cycle it takes up to four 32-bit instructions from a fetch port into a twelve-entry in-order buffer. It then issues up to four of the oldest entries. Branches and condition-register operations leave on two internal ports. Fixed-point and floating-point operations leave on two external ports in program order, in any mix. Decode is reduced to a 3-bit class tag that arrives with each fetched instruction.

When a conditional branch issues, the block does not wait for its outcome. It keeps issuing the fall-through instructions that follow, marking each one speculative and stamping it with the branch's tag. Instructions that fetch has marked as taken-path may sit in the buffer, but they never issue while marked. The outcome arrives on a resolve input:
- **Taken:** the block emits a one-cycle kill naming the tag. It drops the buffered fall-through entries and releases the taken-path entries as ordinary work.
- **Not taken:** it drops the taken-path entries instead.

Top module: `ibuf_dispatch`

## Requirements
- R1: After reset the buffer is empty, no output port is valid, `fetch_ready` is high and no branch is pending; the first conditional branch issued after reset carries tag 1.
- R2: While `fetch_ready` is high, every valid fetch lane is appended behind the buffered entries in ascending lane order. `fetch_ready` is low when fewer than 4 of the 12 entries are free, and also in a cycle where a resolve acts. Lanes offered while `fetch_ready` is low are ignored.
- R3: Class encoding: 0 fixed, 1 floating, 2 condition-register, 3 unconditional branch, 4 conditional branch, and 5 to 7 are treated as fixed. Each cycle the four oldest entries are examined in order. Issue stops at the first entry that cannot leave. At most one branch (branch port) and one condition-register operation (CR port) issue per cycle.
- R4: The oldest issuing external instruction is offered on port 0. The next one is offered on port 1, but only while port 0 is ready. Any fixed/floating mix is allowed, and `xN_float` is high for class 1.
- R5: An external instruction that is offered but not accepted stays in the buffer and blocks every younger instruction, internal ones included.
- R6: An unconditional branch issues in the same cycle as the external and CR instructions behind it.
- R7: A conditional branch issues with its tag on `br_tag`, and the tag increments on each such branch. From that branch's cycle until resolve, every external issue carries `xN_spec`=1 and that tag.
- R8: While a branch is pending, a second conditional branch does not issue and blocks younger entries. An entry fetched with `fetch_tpath`=1 never issues while marked, and blocks younger entries.
- R9: A resolve with `res_taken`=1 while a branch is pending raises `kill_valid` in the same cycle, with `kill_tag` equal to the branch tag. Unmarked entries are discarded, and marked entries remain in order with the mark cleared. Nothing issues in that cycle.
- R10: A resolve with `res_taken`=0 while a branch is pending gives no kill. Marked entries are discarded and unmarked entries remain. Nothing issues in that cycle.
- R11: `res_valid` with no branch pending has no effect: no kill, and issue and fetch proceed as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 4 | Lane valid mask |
| fetch_instr | input | 128 | Lane instructions, lane j in bits 32j+31:32j |
| fetch_cls | input | 12 | Lane class tags, lane j in bits 3j+2:3j |
| fetch_tpath | input | 4 | Lane belongs to the taken path of the pending branch |
| fetch_ready | output | 1 | Buffer accepts the fetch group this cycle |
| br_valid | output | 1 | Branch issued internally |
| br_instr | output | 32 | Branch instruction |
| br_cond | output | 1 | Issued branch is conditional |
| br_tag | output | 3 | Tag of issued conditional branch |
| cr_valid | output | 1 | Condition-register operation issued |
| cr_instr | output | 32 | Condition-register instruction |
| x0_valid | output | 1 | External port 0 offer |
| x0_ready | input | 1 | External port 0 accepts |
| x0_instr | output | 32 | Port 0 instruction |
| x0_float | output | 1 | Port 0 instruction is floating-point |
| x0_spec | output | 1 | Port 0 instruction is speculative |
| x0_tag | output | 3 | Port 0 branch tag |
| x1_valid | output | 1 | External port 1 offer |
| x1_ready | input | 1 | External port 1 accepts |
| x1_instr | output | 32 | Port 1 instruction |
| x1_float | output | 1 | Port 1 instruction is floating-point |
| x1_spec | output | 1 | Port 1 instruction is speculative |
| x1_tag | output | 3 | Port 1 branch tag |
| res_valid | input | 1 | Branch outcome present |
| res_taken | input | 1 | Outcome is taken |
| kill_valid | output | 1 | Cancel speculative work of `kill_tag` |
| kill_tag | output | 3 | Tag to cancel |

## Verification
The properties rely on a few conditions on the inputs:
- Fetch lanes count only while `fetch_ready` is high.
- A resolve is a single-cycle pulse.
- Lanes are marked taken-path only behind a conditional branch that is still unresolved.

The stimulus keeps within these conditions as follows:
- It presents fetch groups only on cycles where the buffer has room, or deliberately while it is full to show they are dropped.
- It marks taken-path lanes only in groups headed by a conditional branch.
- It pulses resolve for exactly one cycle, after the branch has issued.

A full sweep over every class combination of a four-wide group, starting from an empty buffer with both external ports ready, is compared against routing computed from the requirement rules.

// File: rtl/ibuf_dispatch.sv
module ibuf_dispatch #(
  parameter int W     = 32,
  parameter int DEPTH = 12,
  parameter int FW    = 4,
  parameter int TW    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FW-1:0]   fetch_valid,
  input  logic [FW*W-1:0] fetch_instr,
  input  logic [FW*3-1:0] fetch_cls,
  input  logic [FW-1:0]   fetch_tpath,
  output logic            fetch_ready,
  output logic            br_valid,
  output logic [W-1:0]    br_instr,
  output logic            br_cond,
  output logic [TW-1:0]   br_tag,
  output logic            cr_valid,
  output logic [W-1:0]    cr_instr,
  output logic            x0_valid,
  input  logic            x0_ready,
  output logic [W-1:0]    x0_instr,
  output logic            x0_float,
  output logic            x0_spec,
  output logic [TW-1:0]   x0_tag,
  output logic            x1_valid,
  input  logic            x1_ready,
  output logic [W-1:0]    x1_instr,
  output logic            x1_float,
  output logic            x1_spec,
  output logic [TW-1:0]   x1_tag,
  input  logic            res_valid,
  input  logic            res_taken,
  output logic            kill_valid,
  output logic [TW-1:0]   kill_tag
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] C_FLT = 3'd1, C_CR = 3'd2, C_UBR = 3'd3, C_CBR = 3'd4;

  logic [W-1:0]     q_ins [DEPTH];
  logic [2:0]       q_cls [DEPTH];
  logic [DEPTH-1:0] q_tp;
  logic [CW-1:0]    cnt_q;
  logic             pend_q;
  logic [TW-1:0]    tag_q;

  logic [W-1:0]     n_ins [DEPTH];
  logic [2:0]       n_cls [DEPTH];
  logic [DEPTH-1:0] n_tp;
  logic [CW-1:0]    n_cnt;
  logic             pend_d;
  logic [TW-1:0]    tag_d;
  int               n_out;

  wire res_act = res_valid & pend_q;
  assign kill_valid  = res_act & res_taken;
  assign kill_tag    = tag_q;
  assign fetch_ready = !res_act && (int'(cnt_q) <= DEPTH - FW);

  always_comb begin
    logic stop, bu, cu, pend;
    logic [TW-1:0] tg;
    int ext;
    br_valid = 1'b0; br_instr = '0; br_cond = 1'b0; br_tag = '0;
    cr_valid = 1'b0; cr_instr = '0;
    x0_valid = 1'b0; x0_instr = '0; x0_float = 1'b0; x0_spec = 1'b0; x0_tag = '0;
    x1_valid = 1'b0; x1_instr = '0; x1_float = 1'b0; x1_spec = 1'b0; x1_tag = '0;
    stop = res_act; bu = 1'b0; cu = 1'b0; pend = pend_q; tg = tag_q; ext = 0; n_out = 0;
    for (int i = 0; i < FW; i++) begin
      if (!stop && i < int'(cnt_q)) begin
        if (q_tp[i]) stop = 1'b1;
        else if (q_cls[i] == C_UBR || q_cls[i] == C_CBR) begin
          if (bu || (q_cls[i] == C_CBR && pend)) stop = 1'b1;
          else begin
            bu = 1'b1;
            if (q_cls[i] == C_CBR) begin pend = 1'b1; tg = tg + 1'b1; end
            br_valid = 1'b1; br_instr = q_ins[i]; br_cond = (q_cls[i] == C_CBR); br_tag = tg;
            n_out++;
          end
        end else if (q_cls[i] == C_CR) begin
          if (cu) stop = 1'b1;
          else begin cu = 1'b1; cr_valid = 1'b1; cr_instr = q_ins[i]; n_out++; end
        end else if (ext == 0) begin
          x0_valid = 1'b1; x0_instr = q_ins[i]; x0_float = (q_cls[i] == C_FLT);
          x0_spec = pend; x0_tag = tg;
          if (x0_ready) begin ext = 1; n_out++; end else stop = 1'b1;
        end else if (ext == 1) begin
          x1_valid = 1'b1; x1_instr = q_ins[i]; x1_float = (q_cls[i] == C_FLT);
          x1_spec = pend; x1_tag = tg;
          if (x1_ready) begin ext = 2; n_out++; end else stop = 1'b1;
        end else stop = 1'b1;
      end
    end
    pend_d = res_act ? 1'b0 : pend;
    tag_d  = tg;
  end

  always_comb begin
    int pos;
    n_ins = q_ins; n_cls = q_cls; n_tp = q_tp;
    pos = 0;
    if (res_act) begin
      n_tp = '0;
      for (int i = 0; i < DEPTH; i++)
        if (i < int'(cnt_q) && (res_taken ? q_tp[i] : !q_tp[i])) begin
          n_ins[pos] = q_ins[i]; n_cls[pos] = q_cls[i];
          pos++;
        end
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (i + n_out < DEPTH) begin
          n_ins[i] = q_ins[i+n_out]; n_cls[i] = q_cls[i+n_out]; n_tp[i] = q_tp[i+n_out];
        end
      pos = int'(cnt_q) - n_out;
      for (int j = 0; j < FW; j++)
        if (fetch_ready && fetch_valid[j] && pos < DEPTH) begin
          n_ins[pos] = fetch_instr[j*W +: W];
          n_cls[pos] = fetch_cls[j*3 +: 3];
          n_tp[pos]  = fetch_tpath[j];
          pos++;
        end
    end
    n_cnt = CW'(pos);
  end

  always_ff @(posedge clk) begin
    q_ins <= n_ins;
    q_cls <= n_cls;
    if (!rst_n) begin
      cnt_q <= '0; pend_q <= 1'b0; tag_q <= '0; q_tp <= '0;
    end else begin
      cnt_q <= n_cnt; pend_q <= pend_d; tag_q <= tag_d; q_tp <= n_tp;
    end
  end
endmodule

// File: rtl/ibuf_dispatch_chk.sv
module ibuf_dispatch_chk #(
  parameter int DEPTH = 12,
  parameter int FW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          fetch_ready,
  input logic          x0_valid,
  input logic          x0_ready,
  input logic          x1_valid,
  input logic          br_valid,
  input logic          br_cond,
  input logic          cr_valid,
  input logic          kill_valid
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH); // R2
  AST_ROOM_FOR_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> int'(cnt) <= DEPTH - FW); // R2
  AST_PORT1_BEHIND_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
    x1_valid |-> (x0_valid && x0_ready)); // R4
  AST_QUIET_ON_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    kill_valid |-> !(x0_valid || x1_valid || br_valid || cr_valid)); // R9
  AST_ONE_COND_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond) |=> !(br_valid && br_cond)); // R8
endmodule

bind ibuf_dispatch ibuf_dispatch_chk #(.DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .fetch_ready(fetch_ready),
  .x0_valid(x0_valid), .x0_ready(x0_ready), .x1_valid(x1_valid),
  .br_valid(br_valid), .br_cond(br_cond), .cr_valid(cr_valid), .kill_valid(kill_valid)
);

// File: tb/sim_ibuf_dispatch.sv
module sim_ibuf_dispatch;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] fv = '0, ftp = '0;
  logic [127:0] fi = '0;
  logic [11:0] fc = '0;
  logic fetch_ready, br_valid, br_cond, cr_valid, x0_valid, x1_valid;
  logic x0_ready = 1'b1, x1_ready = 1'b1, res_valid = 1'b0, res_taken = 1'b0;
  logic [31:0] br_instr, cr_instr, x0_instr, x1_instr;
  logic x0_float, x0_spec, x1_float, x1_spec, kill_valid;
  logic [2:0] br_tag, x0_tag, x1_tag, kill_tag;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibuf_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_instr(fi), .fetch_cls(fc),
    .fetch_tpath(ftp), .fetch_ready(fetch_ready),
    .br_valid(br_valid), .br_instr(br_instr), .br_cond(br_cond), .br_tag(br_tag),
    .cr_valid(cr_valid), .cr_instr(cr_instr),
    .x0_valid(x0_valid), .x0_ready(x0_ready), .x0_instr(x0_instr), .x0_float(x0_float),
    .x0_spec(x0_spec), .x0_tag(x0_tag),
    .x1_valid(x1_valid), .x1_ready(x1_ready), .x1_instr(x1_instr), .x1_float(x1_float),
    .x1_spec(x1_spec), .x1_tag(x1_tag),
    .res_valid(res_valid), .res_taken(res_taken), .kill_valid(kill_valid), .kill_tag(kill_tag));

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic lane(input int j, input int cls, input logic [31:0] ins, input logic tp);
    fv[j] = 1'b1; fi[j*32 +: 32] = ins; fc[j*3 +: 3] = cls[2:0]; ftp[j] = tp;
  endtask

  task automatic nofetch();
    fv = '0; ftp = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; nofetch(); res_valid = 1'b0; x0_ready = 1'b1; x1_ready = 1'b1;
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  task automatic model(input int c[4], output int ebr, output int ecr, output int ex0,
                       output int ex1, output logic s0, output logic s1);
    logic stop, bu, cu, p;
    int e;
    stop = 0; bu = 0; cu = 0; p = 0; e = 0;
    ebr = -1; ecr = -1; ex0 = -1; ex1 = -1; s0 = 0; s1 = 0;
    for (int j = 0; j < 4; j++) begin
      if (!stop) begin
        if (c[j] == 3 || c[j] == 4) begin
          if (bu) stop = 1; else begin bu = 1; ebr = j; if (c[j] == 4) p = 1; end
        end else if (c[j] == 2) begin
          if (cu) stop = 1; else begin cu = 1; ecr = j; end
        end else if (e == 0) begin ex0 = j; s0 = p; e = 1; end
        else if (e == 1) begin ex1 = j; s1 = p; e = 2; end
        else stop = 1;
      end
    end
  endtask

  function automatic logic [31:0] wd(input int n, input int j);
    return 32'h1000_0000 | 32'(n << 4) | 32'(j);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", {fetch_ready, br_valid, cr_valid, x0_valid, x1_valid, kill_valid}, {1'b1, 5'b0});

    // R3 R4 R6 sweep over class combinations from an empty buffer
    for (int n = 0; n < 1296; n++) begin
      int c[4], ebr, ecr, ex0, ex1;
      logic s0, s1;
      logic [159:0] act, exp;
      do_reset();
      @(negedge clk);
      c[0] = n % 6; c[1] = (n / 6) % 6; c[2] = (n / 36) % 6; c[3] = (n / 216) % 6;
      for (int j = 0; j < 4; j++) lane(j, c[j], wd(n, j), 1'b0);
      step(); nofetch(); #1;
      model(c, ebr, ecr, ex0, ex1, s0, s1);
      act = {br_valid, br_valid ? br_instr : 32'h0, cr_valid, cr_valid ? cr_instr : 32'h0,
             x0_valid, x0_valid ? x0_instr : 32'h0, x0_valid & x0_spec,
             x1_valid, x1_valid ? x1_instr : 32'h0, x1_valid & x1_spec};
      exp = {ebr >= 0, ebr >= 0 ? wd(n, ebr) : 32'h0, ecr >= 0, ecr >= 0 ? wd(n, ecr) : 32'h0,
             ex0 >= 0, ex0 >= 0 ? wd(n, ex0) : 32'h0, ex0 >= 0 && s0,
             ex1 >= 0, ex1 >= 0 ? wd(n, ex1) : 32'h0, ex1 >= 0 && s1};
      chk("R3_R4_R6 sweep", act, exp);
    end

    // R6 unconditional branch with externals and CR in one cycle
    do_reset(); @(negedge clk);
    lane(0, 3, 32'hB0, 0); lane(1, 0, 32'hB1, 0); lane(2, 1, 32'hB2, 0); lane(3, 2, 32'hB3, 0);
    step(); nofetch(); #1;
    chk("R6", {br_valid, br_cond, x0_valid, x0_instr, x1_valid, x1_instr, x1_float, cr_valid},
        {1'b1, 1'b0, 1'b1, 32'hB1, 1'b1, 32'hB2, 1'b1, 1'b1});

    // R2 gapped lane mask keeps lane order
    do_reset(); @(negedge clk);
    lane(1, 0, 32'hC1, 0); lane(3, 0, 32'hC3, 0);
    step(); nofetch(); #1;
    chk("R2 lane order", {x0_valid, x0_instr, x1_valid, x1_instr}, {1'b1, 32'hC1, 1'b1, 32'hC3});

    // R5 backpressure
    do_reset(); @(negedge clk); x0_ready = 0; x1_ready = 0;
    for (int j = 0; j < 4; j++) lane(j, 0, 32'hA0 + 32'(j), 0);
    step(); nofetch(); #1;
    chk("R5 offer", {x0_valid, x0_instr, x1_valid}, {1'b1, 32'hA0, 1'b0});
    step();
    chk("R5 held", {x0_valid, x0_instr}, {1'b1, 32'hA0});
    x0_ready = 1; #1;
    chk("R4 port1 offered", {x0_instr, x1_valid, x1_instr}, {32'hA0, 1'b1, 32'hA1});
    step();
    chk("R5 not lost", {x0_valid, x0_instr}, {1'b1, 32'hA1});
    x1_ready = 1; step();
    chk("R5 drain", {x0_valid, x0_instr, x1_valid}, {1'b1, 32'hA3, 1'b0});
    do_reset(); @(negedge clk); x0_ready = 0;
    lane(0, 0, 32'hD0, 0); lane(1, 2, 32'hD1, 0);
    step(); nofetch(); #1;
    chk("R5 blocks internal", {x0_valid, cr_valid}, {1'b1, 1'b0});

    // R2 fill, stall and ignored lanes
    do_reset(); x0_ready = 0; x1_ready = 0;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      for (int j = 0; j < 4; j++) lane(j, 0, 32'h100 * 32'(b) + 32'(j), 0);
      step(); nofetch(); #1;
      chk("R2 ready", {31'b0, fetch_ready}, {31'b0, (b < 2)});
    end
    x0_ready = 1; x1_ready = 1; #1;
    begin
      int got = 0, bad = 0;
      for (int k = 0; k < 10; k++) begin
        if (x0_valid) begin
          if (x0_instr != 32'h100 * 32'(got / 4) + 32'(got % 4)) bad++;
          got++;
        end
        if (x1_valid) begin
          if (x1_instr != 32'h100 * 32'(got / 4) + 32'(got % 4)) bad++;
          got++;
        end
        step();
      end
      chk("R2 drain count", 160'(got), 160'd12);
      chk("R2 drain order", 160'(bad), 160'd0);
    end

    // R7 R9 taken resolve
    do_reset(); @(negedge clk);
    lane(0, 4, 32'hE0, 0); lane(1, 0, 32'hE1, 0); lane(2, 1, 32'hE2, 1); lane(3, 0, 32'hE3, 0);
    step(); nofetch(); #1;
    chk("R7 issue", {br_valid, br_cond, br_tag, x0_valid, x0_instr, x0_spec, x0_tag, x1_valid},
        {1'b1, 1'b1, 3'd1, 1'b1, 32'hE1, 1'b1, 3'd1, 1'b0});
    step();
    chk("R8 marked held", {x0_valid, x1_valid, br_valid}, 3'b0);
    res_valid = 1; res_taken = 1; #1;
    chk("R9 kill", {kill_valid, kill_tag, x0_valid, fetch_ready}, {1'b1, 3'd1, 1'b0, 1'b0});
    step(); res_valid = 0; #1;
    chk("R9 release", {kill_valid, x0_valid, x0_instr, x0_spec, x0_float, x1_valid},
        {1'b0, 1'b1, 32'hE2, 1'b0, 1'b1, 1'b0});
    step();
    chk("R9 discard", {x0_valid, x1_valid}, 2'b0);

    // R10 not-taken resolve
    do_reset(); @(negedge clk);
    lane(0, 4, 32'hF0, 0); lane(1, 0, 32'hF1, 0); lane(2, 0, 32'hF2, 1); lane(3, 4, 32'hF3, 0);
    step(); nofetch(); step();
    res_valid = 1; res_taken = 0; #1;
    chk("R10 no kill", {kill_valid, x0_valid, br_valid}, 3'b0);
    step(); res_valid = 0; #1;
    chk("R10 discard", {x0_valid, br_valid, br_instr, br_tag}, {1'b0, 1'b1, 32'hF3, 3'd2});

    // R8 second conditional waits
    do_reset(); @(negedge clk);
    lane(0, 4, 32'h70, 0); lane(1, 0, 32'h71, 0); lane(2, 4, 32'h72, 0); lane(3, 0, 32'h73, 0);
    step(); nofetch(); #1;
    chk("R8 block", {br_instr, x0_instr, x1_valid}, {32'h70, 32'h71, 1'b0});
    step();
    chk("R8 pending", {br_valid, x0_valid}, 2'b0);
    res_valid = 1; res_taken = 0; step(); res_valid = 0; #1;
    chk("R8 after", {br_valid, br_instr, br_tag, x0_valid, x0_instr, x0_spec, x0_tag},
        {1'b1, 32'h72, 3'd2, 1'b1, 32'h73, 1'b1, 3'd2});

    // R11 resolve with nothing pending
    do_reset(); @(negedge clk); lane(0, 0, 32'h90, 0);
    step(); nofetch(); res_valid = 1; res_taken = 1; #1;
    chk("R11", {kill_valid, x0_valid, x0_instr, fetch_ready}, {1'b0, 1'b1, 32'h90, 1'b1});
    step(); res_valid = 0; #1;
    chk("R11 consumed", {x0_valid}, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule